// File: doc/BRIEF.md
# Sampled-Set Fill Granularity Chooser

This block decides how many blocks a DRAM cache fetches on each fill from the slower memory behind it. Main memory rows are grouped into row sets. A small number of row sets act as samples. Each sample is tied permanently to one of four candidate granularities: 1, 2, 4 or 8 blocks. Every other row set uses the granularity that currently scores best. The cache controller reports two kinds of event. An access event carries a row-set index and the latency that access took. A fill event carries the row-set index of a caching operation. For every candidate, the block adds up the latency seen on that candidate's sample sets and counts its fills. At the end of each fixed quantum it picks the candidate with the lowest weighted cost, and that candidate becomes the granularity for all non-sampled sets.

Both event inputs are valid/ready streams. The block never applies back-pressure: each ready is held high, and an event is taken on every clock edge where its valid is high. A separate lookup port returns the granularity for any row-set index within the same cycle. The current winner is also output directly.

Top module: `gran_selector`

## Requirements
- R1: `acc_ready` and `fill_ready` are always 1. An event is counted on each rising edge where its valid is high. An access and a fill may arrive in the same cycle.
- R2: A row set is a sample when its index modulo 32 (the low 5 index bits) is 0, 1, 2 or 3. For such a set, `lk_gran` equals that value. Granularity codes 0, 1, 2, 3 stand for 1, 2, 4 and 8 blocks.
- R3: For any row set that is not a sample, `lk_gran` equals `win_gran` in the same cycle.
- R4: A candidate's cost is the sum of the latencies of the accesses to its sample sets, plus FILL_WEIGHT (default 64) times the number of fills to its sample sets. Events on non-sampled sets change no cost.
- R5: The candidate with the lowest cost becomes the winner. When costs are equal, the smaller code wins.
- R6: A quantum is QUANTUM cycles long, counted from the first edge after reset. `win_gran` changes only on the edge that ends a quantum.
- R7: Costs restart from zero in every quantum. An event accepted on the edge that ends a quantum counts toward the next quantum.
- R8: The latency sum and the fill count each saturate at their maximum value instead of wrapping.
- R9: After reset, `win_gran` is 0 (1 block) and every cost is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access event present |
| acc_ready | output | 1 | Always 1 |
| acc_set | input | SET_W | Row-set index of the access |
| acc_lat | input | LAT_W | Latency of the access |
| fill_valid | input | 1 | Fill event present |
| fill_ready | output | 1 | Always 1 |
| fill_set | input | SET_W | Row-set index of the fill |
| lk_set | input | SET_W | Row-set index to look up |
| lk_gran | output | 2 | Granularity code for `lk_set` |
| win_gran | output | 2 | Current winning granularity code |

## Verification
Two things can happen on the same edge: the winner is chosen at the end of a quantum, and a new access is taken into the accumulators. The bench keeps its own model of the quantum phase and drives a large-latency access exactly on the edge that ends a quantum. It then checks that this access does not affect the winner picked on that edge, and that it does decide the winner picked at the end of the following quantum. The bench also checks the winner one cycle before a boundary, to confirm that events arriving earlier in the quantum have not moved it yet.

// File: rtl/gsel_pkg.sv
package gsel_pkg;
  typedef enum logic [1:0] {
    GR_1BLK = 2'd0,
    GR_2BLK = 2'd1,
    GR_4BLK = 2'd2,
    GR_8BLK = 2'd3
  } gran_e;

  localparam int unsigned NUM_GRAN = 4;
  localparam int unsigned GRAN_W   = 2;
endpackage

// File: rtl/gsel_set_map.sv
module gsel_set_map #(
  parameter int unsigned SET_W    = 16,
  parameter int unsigned PERIOD_W = 5
) (
  input  logic [SET_W-1:0]             set_idx,
  output logic                         sampled,
  output logic [gsel_pkg::GRAN_W-1:0]  cand
);
  localparam int unsigned PW = PERIOD_W;

  logic [PW-1:0] phase;

  always_comb begin
    phase   = set_idx[PW-1:0];
    sampled = (phase < PW'(gsel_pkg::NUM_GRAN));
    cand    = phase[gsel_pkg::GRAN_W-1:0];
  end
endmodule

// File: rtl/gsel_acc.sv
module gsel_acc #(
  parameter int unsigned LAT_W       = 12,
  parameter int unsigned ACC_W       = 32,
  parameter int unsigned FILL_W      = 16,
  parameter int unsigned FILL_WEIGHT = 64,
  parameter int unsigned COST_W      = ACC_W + FILL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              lat_en,
  input  logic [LAT_W-1:0]  lat_in,
  input  logic              fill_en,
  output logic [COST_W-1:0] cost
);
  logic [ACC_W-1:0]  lat_q;
  logic [FILL_W-1:0] fill_q;
  logic [ACC_W-1:0]  lat_add;
  logic [ACC_W:0]    lat_sum;
  logic [FILL_W:0]   fill_sum;

  always_comb begin
    lat_add  = lat_en ? ACC_W'(lat_in) : '0;
    lat_sum  = {1'b0, lat_q} + {1'b0, lat_add};
    fill_sum = {1'b0, fill_q} + (FILL_W+1)'(fill_en);
    cost     = COST_W'(lat_q) + COST_W'(FILL_WEIGHT) * COST_W'(fill_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      fill_q <= '0;
    end else if (clr) begin
      lat_q  <= lat_add;
      fill_q <= FILL_W'(fill_en);
    end else begin
      lat_q  <= lat_sum[ACC_W]   ? '1 : lat_sum[ACC_W-1:0];
      fill_q <= fill_sum[FILL_W] ? '1 : fill_sum[FILL_W-1:0];
    end
  end

  // R7: a boundary with no event leaves the sums empty
  assert_clear_on_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && !lat_en && !fill_en) |=> (lat_q == '0 && fill_q == '0));

  // R8: inside a quantum the sums never go down
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (lat_q >= $past(lat_q) && fill_q >= $past(fill_q)));
endmodule

// File: rtl/gsel_argmin.sv
module gsel_argmin #(
  parameter int unsigned COST_W = 48
) (
  input  logic [gsel_pkg::NUM_GRAN-1:0][COST_W-1:0] cost,
  output logic [gsel_pkg::GRAN_W-1:0]               best
);
  always_comb begin
    best = '0;
    for (int i = 1; i < int'(gsel_pkg::NUM_GRAN); i++) begin
      if (cost[i] < cost[best]) best = gsel_pkg::GRAN_W'(i);
    end
  end
endmodule

// File: rtl/gran_selector.sv
module gran_selector #(
  parameter int unsigned SET_W       = 16,
  parameter int unsigned PERIOD_W    = 5,
  parameter int unsigned LAT_W       = 12,
  parameter int unsigned ACC_W       = 32,
  parameter int unsigned FILL_W      = 16,
  parameter int unsigned FILL_WEIGHT = 64,
  parameter int unsigned QUANTUM     = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [SET_W-1:0] acc_set,
  input  logic [LAT_W-1:0] acc_lat,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [SET_W-1:0] fill_set,
  input  logic [SET_W-1:0] lk_set,
  output logic [1:0]       lk_gran,
  output logic [1:0]       win_gran
);
  import gsel_pkg::*;

  localparam int unsigned COST_W = ACC_W + FILL_W + 1;
  localparam int unsigned QW     = (QUANTUM > 2) ? $clog2(QUANTUM) : 1;

  logic [QW-1:0]     q_cnt;
  logic              boundary;
  gran_e             win_q;
  logic [GRAN_W-1:0] best;
  logic [NUM_GRAN-1:0][COST_W-1:0] cost;

  logic              a_samp, f_samp, l_samp;
  logic [GRAN_W-1:0] a_cand, f_cand, l_cand;

  assign acc_ready  = 1'b1;
  assign fill_ready = 1'b1;
  assign boundary   = (q_cnt == QW'(QUANTUM - 1));

  always_ff @(posedge clk) begin
    if (rst)           q_cnt <= '0;
    else if (boundary) q_cnt <= '0;
    else               q_cnt <= q_cnt + 1'b1;
  end

  gsel_set_map #(.SET_W(SET_W), .PERIOD_W(PERIOD_W)) u_amap (
    .set_idx(acc_set), .sampled(a_samp), .cand(a_cand));
  gsel_set_map #(.SET_W(SET_W), .PERIOD_W(PERIOD_W)) u_fmap (
    .set_idx(fill_set), .sampled(f_samp), .cand(f_cand));
  gsel_set_map #(.SET_W(SET_W), .PERIOD_W(PERIOD_W)) u_lmap (
    .set_idx(lk_set), .sampled(l_samp), .cand(l_cand));

  for (genvar g = 0; g < NUM_GRAN; g++) begin : g_cand
    logic lat_hit, fill_hit;
    assign lat_hit  = acc_valid  && a_samp && (a_cand == GRAN_W'(g));
    assign fill_hit = fill_valid && f_samp && (f_cand == GRAN_W'(g));

    gsel_acc #(
      .LAT_W(LAT_W), .ACC_W(ACC_W), .FILL_W(FILL_W),
      .FILL_WEIGHT(FILL_WEIGHT), .COST_W(COST_W)
    ) u_acc (
      .clk(clk), .rst(rst), .clr(boundary),
      .lat_en(lat_hit), .lat_in(acc_lat), .fill_en(fill_hit),
      .cost(cost[g])
    );

    // R5: the chosen candidate is never beaten, and ties go to the lower code
    assert_lowest_cost_R5: assert property (@(posedge clk) disable iff (rst)
      (cost[best] <= cost[g]) && ((cost[g] == cost[best]) -> (best <= GRAN_W'(g))));
  end

  gsel_argmin #(.COST_W(COST_W)) u_pick (.cost(cost), .best(best));

  always_ff @(posedge clk) begin
    if (rst)           win_q <= GR_1BLK;
    else if (boundary) win_q <= gran_e'(best);
  end

  assign win_gran = win_q;
  assign lk_gran  = l_samp ? l_cand : win_q;

  // R1: the block never stalls either event stream
  assert_always_ready_R1: assert property (@(posedge clk) disable iff (rst)
    acc_ready && fill_ready);

  // R6: the winner holds between quantum boundaries
  assert_winner_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(win_gran));

  // R2: a sample set reports its own candidate
  assert_sample_lookup_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_set[PERIOD_W-1:0] < PERIOD_W'(NUM_GRAN)) |-> (lk_gran == lk_set[1:0]));

  // R3: any other set follows the winner
  assert_follow_lookup_R3: assert property (@(posedge clk) disable iff (rst)
    (lk_set[PERIOD_W-1:0] >= PERIOD_W'(NUM_GRAN)) |-> (lk_gran == win_gran));
endmodule

// File: tb/test_gran_selector.sv
module test_gran_selector;
  localparam int SET_W = 10;
  localparam int Q     = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0, fill_valid = 1'b0;
  logic acc_ready, fill_ready;
  logic [SET_W-1:0] acc_set = '0, fill_set = '0, lk_set = '0;
  logic [11:0] acc_lat = '0;
  logic [1:0] lk_gran, win_gran;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gran_selector #(
    .SET_W(SET_W), .PERIOD_W(5), .LAT_W(12), .ACC_W(12), .FILL_W(8),
    .FILL_WEIGHT(64), .QUANTUM(Q)
  ) i_gran_selector (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_set(acc_set), .acc_lat(acc_lat),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_set(fill_set),
    .lk_set(lk_set), .lk_gran(lk_gran), .win_gran(win_gran)
  );

  // quantum phase model: number of edges since reset, modulo Q
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= (cyc == Q-1) ? 0 : cyc + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ev_acc(input int s, input int lat);
    acc_valid = 1'b1; acc_set = SET_W'(s); acc_lat = 12'(lat);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic ev_fill(input int s);
    fill_valid = 1'b1; fill_set = SET_W'(s);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input string tag, input int s, input int exp);
    lk_set = SET_W'(s);
    #1;
    chk(tag, int'(lk_gran), exp);
  endtask

  // advance to the negedge right after the next quantum boundary
  task automatic to_boundary();
    do @(negedge clk); while (cyc != 0);
  endtask

  task automatic t_reset();
    chk("R9 winner after reset", int'(win_gran), 0);
    chk("R1 acc_ready", int'(acc_ready), 1);
    chk("R1 fill_ready", int'(fill_ready), 1);
    look("R2 sample set 33", 33, 1);
    look("R2 sample set 3", 3, 3);
    look("R3 plain set 5", 5, 0);
  endtask

  task automatic t_idle_tie();
    to_boundary();
    chk("R5 all-zero tie picks code 0", int'(win_gran), 0);
  endtask

  task automatic t_latency_pick();
    ev_acc(0, 500); ev_acc(1, 400); ev_acc(2, 100); ev_acc(3, 300);
    ev_acc(40, 4000); ev_fill(44); ev_fill(36);   // non-sampled: no effect (R4)
    to_boundary();
    chk("R4 lowest latency picks code 2", int'(win_gran), 2);
    look("R3 plain set 100 follows winner", 100, 2);
    look("R2 sample set 65 keeps code 1", 65, 1);
  endtask

  task automatic t_fill_weight();
    ev_acc(0, 500); ev_acc(1, 500); ev_acc(34, 100); ev_acc(3, 300);
    for (int k = 0; k < 5; k++) ev_fill(2);
    to_boundary();
    chk("R4 fill weight moves winner to 3", int'(win_gran), 3);
  endtask

  task automatic t_clear_and_tie();
    ev_acc(0, 50); ev_acc(1, 20); ev_acc(2, 20); ev_acc(3, 80);
    to_boundary();
    chk("R7 fresh sums with tie pick 1", int'(win_gran), 1);
  endtask

  task automatic t_hold();
    ev_acc(1, 100); ev_acc(2, 100); ev_acc(3, 100);
    do @(negedge clk); while (cyc != Q-1);
    chk("R6 winner held before boundary", int'(win_gran), 1);
    look("R3 plain set 9 before boundary", 9, 1);
    to_boundary();
    chk("R6 winner updated at boundary", int'(win_gran), 0);
  endtask

  task automatic t_boundary_event();
    ev_acc(0, 10); ev_acc(1, 20); ev_acc(2, 30); ev_acc(3, 5);
    do @(negedge clk); while (cyc != Q-1);
    ev_acc(3, 1000);                 // taken on the boundary edge
    chk("R7 boundary access excluded from ending quantum", int'(win_gran), 3);
    ev_acc(0, 100); ev_acc(1, 100); ev_acc(2, 100);
    to_boundary();
    chk("R7 boundary access counted in next quantum", int'(win_gran), 0);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 5; k++) ev_acc(0, 1000);
    ev_acc(1, 4094); ev_acc(2, 4095); ev_acc(3, 4095);
    to_boundary();
    chk("R8 saturated sum loses to 4094", int'(win_gran), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle_tie();
    t_latency_pick();
    t_fill_weight();
    t_clear_and_tie();
    t_hold();
    t_boundary_event();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule